// File: doc/BRIEF.md
# Receive Byte Queue with Break Capture

This block is a small first-in, first-out store that sits between a byte-level serial receiver and the host's data-register read path. The receiver offers bytes, and a byte is taken only while reception is switched on and the queue has room. The host reads bytes back in the order they arrived. A line-break condition is logged as a zero byte, and a sticky delta-break bit is raised. A break is never refused, so when the queue is already full it takes the place of the newest entry.

The block drives two status flags, receiver-ready (at least one byte held) and full (all slots held), and a ready-to-receive handshake for the receiver. A flush input empties the queue in one cycle. The reset-receiver command uses it. A read returns its byte on the cycle after the request, and a read of an empty queue returns zero.

Top module: `rxq_top`

## Requirements
- R1: After synchronous reset the queue is empty, receiver-ready, full and delta-break are low, and `rd_data` is 0x00.
- R2: Each read with a non-empty queue removes the oldest byte, and that byte appears on `rd_data` one cycle after the request. It stays there until the next read or flush.
- R3: `rx_ready` is high exactly when `rx_en` is high and the full flag is low. A byte offered on `in_valid` while `rx_ready` is low is discarded.
- R4: Receiver-ready rises in the cycle after any byte is stored. It falls after a read that leaves the queue empty.
- R5: The full flag rises when the fourth byte is stored. Any read from a full queue clears it, unless a break stored in the same cycle refills the queue.
- R6: A read of an empty queue returns 0x00 and leaves the flags and contents unchanged.
- R7: A break event sets the delta-break flag and stores a 0x00 byte, whether or not reception is enabled and whether or not the queue is full. A data byte offered in the same cycle is dropped. `dbrk_clr` clears the flag, and a break in the same cycle wins over the clear.
- R8: A break that arrives while the queue is full, with no read in that cycle, overwrites the newest entry with 0x00. The three older bytes stay in place, and the queue stays full.
- R9: `flush` empties the queue and clears receiver-ready and full. In the same cycle it overrides any read, which then returns 0x00, and any store. A break still sets delta-break.
- R10: When a read and a store fall in the same cycle, the read takes effect first and the store second, so no byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Reception enabled |
| in_valid | input | 1 | Receiver offers a byte |
| in_data | input | 8 | Offered byte |
| brk_evt | input | 1 | Line break detected, one-cycle pulse |
| dbrk_clr | input | 1 | Clear delta-break flag |
| rd_req | input | 1 | Host read of the data register |
| flush | input | 1 | Empty the queue (reset-receiver command) |
| rd_data | output | 8 | Byte returned by the last read |
| rx_ready | output | 1 | Receiver may offer a byte |
| rdy_flag | output | 1 | Receiver-ready status |
| full_flag | output | 1 | Queue-full status |
| dbrk_flag | output | 1 | Delta-break status |

## Verification
Removing a byte and storing one can land on the same clock edge. This is most delicate when the queue is full, because the write slot is then the same slot that is being read. The bench provokes this by issuing a read together with a data byte at three entries, and a read together with a break at four entries. It then drains the queue. A reference queue in the bench predicts every returned byte, and the last read of each sequence has to show the stored byte in arrival order with nothing lost or overwritten.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    PK_NONE    = 2'd0,
    PK_APPEND  = 2'd1,
    PK_REPLACE = 2'd2
  } push_kind_e;
endpackage

// File: rtl/rxq_admit.sv
module rxq_admit
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              brk_evt,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rx_en,
  input  logic              full_flag,
  input  logic              pop,
  output push_kind_e        kind,
  output logic [DATA_W-1:0] wdata
);
  always_comb begin
    kind  = PK_NONE;
    wdata = '0;
    if (!flush) begin
      if (brk_evt) begin
        kind = (full_flag && !pop) ? PK_REPLACE : PK_APPEND;
      end else if (in_valid && rx_en && !full_flag) begin
        kind  = PK_APPEND;
        wdata = in_data;
      end
    end
  end

  AST_DISABLED_DROP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rx_en && !brk_evt) |-> (kind == PK_NONE)); // R3
  AST_BREAK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (brk_evt && !flush) |-> (kind != PK_NONE && wdata == '0)); // R7
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int AW     = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          rd_req,
  input  logic          brk_evt,
  input  logic          dbrk_clr,
  input  push_kind_e    kind,
  output logic          pop,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          rdy_flag,
  output logic          full_flag,
  output logic          dbrk_flag,
  output logic          rd_hit
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_n;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] back(input logic [AW-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  assign pop   = rd_req && !flush && rdy_flag;
  assign we    = (kind != PK_NONE);
  assign waddr = (kind == PK_REPLACE) ? back(wptr) : wptr;
  assign raddr = rptr;

  always_comb begin
    cnt_n = cnt;
    if (pop) cnt_n = cnt_n - 1'b1;
    if (kind == PK_APPEND) cnt_n = cnt_n + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr      <= '0;
      rptr      <= '0;
      cnt       <= '0;
      rdy_flag  <= 1'b0;
      full_flag <= 1'b0;
    end else begin
      if (pop) rptr <= bump(rptr);
      if (kind == PK_APPEND) wptr <= bump(wptr);
      cnt       <= cnt_n;
      rdy_flag  <= (cnt_n != '0);
      full_flag <= (cnt_n == CMAX);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbrk_flag <= 1'b0;
      rd_hit    <= 1'b0;
    end else begin
      if (brk_evt) dbrk_flag <= 1'b1;
      else if (dbrk_clr) dbrk_flag <= 1'b0;
      if (rd_req || flush) rd_hit <= pop;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CMAX); // R5
  AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    full_flag |-> rdy_flag); // R5
  AST_POP_CLEARS_FULL: assert property (@(posedge clk) disable iff (rst)
    (rd_req && full_flag && !brk_evt && !flush) |=> !full_flag); // R5
  AST_POP_RETURNS: assert property (@(posedge clk) disable iff (rst)
    pop |=> rd_hit); // R2
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rdy_flag && kind == PK_NONE) |=> (!rdy_flag && !rd_hit)); // R6
  AST_BRK_FLAG: assert property (@(posedge clk) disable iff (rst)
    brk_evt |=> dbrk_flag); // R7
  AST_REPLACE_KEEPS_FULL: assert property (@(posedge clk) disable iff (rst)
    (full_flag && brk_evt && !rd_req && !flush) |=> full_flag); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!rdy_flag && !full_flag)); // R9
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              brk_evt,
  input  logic              dbrk_clr,
  input  logic              rd_req,
  input  logic              flush,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_ready,
  output logic              rdy_flag,
  output logic              full_flag,
  output logic              dbrk_flag
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  push_kind_e        kind;
  logic [DATA_W-1:0] wdata, q;
  logic              pop, we, rd_hit;
  logic [AW-1:0]     waddr, raddr;

  rxq_admit #(.DATA_W(DATA_W)) u_admit (
    .clk(clk), .rst(rst), .flush(flush), .brk_evt(brk_evt),
    .in_valid(in_valid), .in_data(in_data), .rx_en(rx_en),
    .full_flag(full_flag), .pop(pop), .kind(kind), .wdata(wdata)
  );

  rxq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .rd_req(rd_req),
    .brk_evt(brk_evt), .dbrk_clr(dbrk_clr), .kind(kind), .pop(pop),
    .we(we), .waddr(waddr), .raddr(raddr), .rdy_flag(rdy_flag),
    .full_flag(full_flag), .dbrk_flag(dbrk_flag), .rd_hit(rd_hit)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .re(pop), .raddr(raddr), .q(q)
  );

  assign rd_data  = rd_hit ? q : '0;
  assign rx_ready = rx_en && !full_flag;

  AST_STORE_SETS_RDY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rx_ready && !flush) |=> rdy_flag); // R4
  AST_REFUSE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (full_flag && !rd_req && !flush) |=> full_flag); // R3
endmodule

// File: tb/tb_rxq_top.sv
`timescale 1ns/1ps
module tb_rxq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_en = 1'b0, in_valid = 1'b0, brk_evt = 1'b0;
  logic       dbrk_clr = 1'b0, rd_req = 1'b0, flush = 1'b0;
  logic [7:0] in_data = '0;
  logic [7:0] rd_data;
  logic       rx_ready, rdy_flag, full_flag, dbrk_flag;

  int nchk = 0, nfail = 0;
  logic [7:0] mq[$];
  logic [7:0] exp_rd[$];
  string      exp_tag[$];
  logic       m_dbrk = 1'b0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  rxq_top dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .in_valid(in_valid), .in_data(in_data),
    .brk_evt(brk_evt), .dbrk_clr(dbrk_clr), .rd_req(rd_req), .flush(flush),
    .rd_data(rd_data), .rx_ready(rx_ready), .rdy_flag(rdy_flag),
    .full_flag(full_flag), .dbrk_flag(dbrk_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: reads return bytes one cycle after the request (R2)
  initial begin
    forever begin
      logic r_s;
      @(posedge clk);
      r_s = rd_req && !rst;
      #1;
      if (r_s) begin
        logic [7:0] e;
        string t;
        e = exp_rd.pop_front();
        t = exp_tag.pop_front();
        chk(rd_data == e, t, rd_data, e);
      end
    end
  end

  // driver: called at a falling edge; applies one cycle, updates the reference queue
  task automatic step(input logic v, input logic [7:0] d, input logic b,
                      input logic r, input logic f, input logic c, input string tag);
    bit full_before;
    full_before = (mq.size() == 4);
    in_valid = v; in_data = d; brk_evt = b; rd_req = r; flush = f; dbrk_clr = c;
    if (b) m_dbrk = 1'b1;
    else if (c) m_dbrk = 1'b0;
    if (f) begin
      mq.delete();
      if (r) begin exp_rd.push_back(8'h00); exp_tag.push_back(tag); end
    end else begin
      if (r) begin
        if (mq.size() != 0) exp_rd.push_back(mq.pop_front());
        else exp_rd.push_back(8'h00);
        exp_tag.push_back(tag);
      end
      if (b) begin
        if (mq.size() < 4) mq.push_back(8'h00);
        else mq[3] = 8'h00;
      end else if (v && rx_en && !full_before) begin
        mq.push_back(d);
      end
    end
    @(negedge clk);
    in_valid = 0; brk_evt = 0; rd_req = 0; flush = 0; dbrk_clr = 0;
    chk(rdy_flag == (mq.size() != 0), {tag, " rdy"}, rdy_flag, mq.size() != 0);
    chk(full_flag == (mq.size() == 4), {tag, " full"}, full_flag, mq.size() == 4);
    chk(dbrk_flag == m_dbrk, {tag, " dbrk"}, dbrk_flag, m_dbrk);
    chk(rx_ready == (rx_en && mq.size() != 4), {tag, " ready"}, rx_ready,
        rx_en && mq.size() != 4);
  endtask

  task automatic put(input logic [7:0] d, input string tag);
    step(1, d, 0, 0, 0, 0, tag);
  endtask

  task automatic get(input string tag);
    step(0, 8'h00, 0, 1, 0, 0, tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(rdy_flag == 0 && full_flag == 0 && dbrk_flag == 0, "R1 flags",
        {rdy_flag, full_flag, dbrk_flag}, 0);
    chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    // R3: reception off, byte ignored
    put(8'h11, "R3 disabled");
    rx_en = 1;
    put(8'hA1, "R4 first"); put(8'hA2, "R2 fill"); put(8'hA3, "R2 fill");
    get("R2 oldest A1"); get("R2 next A2");
    put(8'hB1, "R2 fill"); put(8'hB2, "R2 fill"); put(8'hB3, "R5 reach four");
    put(8'hEE, "R3 full refuses");
    get("R5 read clears full");
    // R10: read with data byte at three entries
    step(1, 8'hC1, 0, 1, 0, 0, "R10 read+push");
    put(8'hC2, "R5 full again");
    // R10: read with break when full
    step(0, 8'h00, 1, 1, 0, 0, "R10 read+break");
    // R8: break when full replaces newest
    step(0, 8'h00, 1, 0, 0, 0, "R8 replace newest");
    step(0, 8'h00, 0, 0, 0, 1, "R7 clear dbrk");
    get("R8 drain"); get("R8 drain"); get("R8 drain"); get("R4 last empties");
    get("R6 empty read"); get("R6 empty read again");
    // R7: break while reception off, and break beating data
    rx_en = 0;
    step(1, 8'h55, 1, 0, 0, 1, "R7 break wins clear");
    rx_en = 1;
    step(1, 8'h66, 1, 0, 0, 0, "R7 break drops data");
    put(8'h77, "R4 fill");
    get("R7 zero byte"); get("R7 zero byte"); get("R2 tail");
    // R9: flush with read and store in same cycle
    put(8'h81, "R9 fill"); put(8'h82, "R9 fill"); put(8'h83, "R9 fill");
    step(1, 8'h84, 0, 1, 1, 0, "R9 flush");
    get("R9 empty after flush");
    put(8'h91, "R9 after flush"); get("R9 after flush read");
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule